// File: doc/BRIEF.md
# Composite Sine PWM Waveform Generator

This block drives a single switching output with a center-aligned pulse train. The pulse width follows a composite waveform: a DC level plus a sine. The sine uses one amplitude for its positive half-cycle and a separate, usually smaller, amplitude for its negative half-cycle. A power stage and a low-pass filter outside the block turn the pulse train into the analog waveform. The block itself is purely digital.

A triangle counter runs from zero up to the programmed period and back down, so one PWM period lasts twice the period value in clock cycles. Duty values use a full scale of twice the period, which is 100%. At the end of every PWM period, a 16-bit phase accumulator advances by a programmable step. Its top six bits then select one of 64 signed sine samples (peak ±127). The sample is scaled by the amplitude for its sign, divided by 127, added to the level code, and clamped to the legal duty range. The result becomes the duty value for the next period. For example, with a period of 25, a level of 38 and amplitudes of 7 and 2, the duty swings between 36 and 45 out of 50.

Top module: `composite_pwm_gen`

## Requirements
- R1: While enabled, every PWM period lasts exactly 2×P clock cycles, where P is `period_i` (P ≥ 1). The counter counts up from 0 to P and then back down to 1.
- R2: In each PWM period, the output is active for exactly D clock cycles, where D is the duty value in force for that period (full scale 2×P).
- R3: The duty of period n comes from the sine sample addressed by bits [15:10] of the phase n×`step_i` (mod 2^16), counted from the phase held when the output was last enabled. Sample k is round(127·sin(2πk/64)).
- R4: For a sample s ≥ 0, the duty is `level_i` + trunc(s×`amp_pos_i`/127).
- R5: For a sample s < 0, the duty is `level_i` + trunc(s×`amp_neg_i`/127), truncated toward zero.
- R6: The duty is clamped to the range 0 to 2×P. A result below 0 gives an output that is never active. A result above 2×P gives an output that is active for the whole period.
- R7: The duty for a period is loaded from the inputs present in its final clock cycle. It is loaded from the current inputs while disabled. Changing the level or the amplitudes in the middle of a period does not alter that period.
- R8: With `invert_i` = 1, `pwm_o` is low when active and high when inactive. With `invert_i` = 0, `pwm_o` is high when active.
- R9: During reset and while `en` is low, `pwm_o` holds the inactive level (equal to `invert_i`) and `period_end_o` stays low. Reset clears the phase to 0.
- R10: `period_end_o` is high for exactly one cycle per PWM period: the last cycle of that period. The phase advances on that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops and rewinds the counter |
| period_i | input | 8 | Half-period P in clocks; duty full scale is 2×P |
| level_i | input | 9 | DC level duty code |
| amp_pos_i | input | 8 | Amplitude code for the positive half-cycle |
| amp_neg_i | input | 8 | Amplitude code for the negative half-cycle |
| step_i | input | 16 | Phase increment per PWM period |
| invert_i | input | 1 | Selects active-low output |
| pwm_o | output | 1 | Center-aligned PWM output |
| period_end_o | output | 1 | Strobe on the last cycle of each PWM period |

## Verification
The in-RTL assertions check four properties on every cycle:
- the counter turns around at the top of its range;
- the duty register changes only at a period boundary or while idle;
- a freshly loaded duty never exceeds the full scale;
- the idle output level is correct and the strobe never lasts two cycles.

Only the bench's scenarios can show whether the active time of each period matches the sine-scaled, clamped value. This covers the phase sequence for aligned and non-aligned steps, the asymmetric half-cycle amplitudes, both clamp limits, inversion, a one-clock half-period, and a mid-period change of the level.

// File: rtl/composite_pwm_gen.sv
`timescale 1ns/1ps
module composite_pwm_gen #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 16,
  parameter int AMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [CNT_W:0]     level_i,
  input  logic [AMP_W-1:0]   amp_pos_i,
  input  logic [AMP_W-1:0]   amp_neg_i,
  input  logic [ACC_W-1:0]   step_i,
  input  logic               invert_i,
  output logic               pwm_o,
  output logic               period_end_o
);
  localparam int TBL_AW = 6;
  localparam int DUTY_W = CNT_W + 1;
  localparam int MW     = DUTY_W + AMP_W + 10;

  function automatic logic signed [7:0] quarter(input logic [4:0] j);
    case (j)
      5'd0:  quarter = 8'sd0;
      5'd1:  quarter = 8'sd12;
      5'd2:  quarter = 8'sd25;
      5'd3:  quarter = 8'sd37;
      5'd4:  quarter = 8'sd49;
      5'd5:  quarter = 8'sd60;
      5'd6:  quarter = 8'sd71;
      5'd7:  quarter = 8'sd81;
      5'd8:  quarter = 8'sd90;
      5'd9:  quarter = 8'sd98;
      5'd10: quarter = 8'sd106;
      5'd11: quarter = 8'sd112;
      5'd12: quarter = 8'sd117;
      5'd13: quarter = 8'sd122;
      5'd14: quarter = 8'sd125;
      5'd15: quarter = 8'sd126;
      default: quarter = 8'sd127;
    endcase
  endfunction

  function automatic logic signed [7:0] sine_at(input logic [TBL_AW-1:0] a);
    logic [4:0] j;
    logic signed [7:0] m;
    j = a[4] ? 5'd16 - {1'b0, a[3:0]} : {1'b0, a[3:0]};
    m = quarter(j);
    sine_at = a[5] ? -m : m;
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic              down;
  logic [ACC_W-1:0]  phase;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_nx;
  logic [ACC_W-1:0]  phase_nx;
  logic signed [7:0] samp;
  logic [AMP_W-1:0]  amp;
  logic signed [MW-1:0] prod, scaled, sum, full;
  logic period_end, load, active;

  assign period_end = en & down & (cnt <= CNT_W'(1));
  assign load       = ~en | period_end;
  assign phase_nx   = period_end ? phase + step_i : phase;
  assign samp       = sine_at(phase_nx[ACC_W-1 -: TBL_AW]);
  assign amp        = samp[7] ? amp_neg_i : amp_pos_i;

  always_comb begin
    prod   = MW'(samp) * MW'($signed({1'b0, amp}));
    scaled = prod / MW'(127);
    sum    = MW'($signed({1'b0, level_i})) + scaled;
    full   = MW'($signed({1'b0, period_i, 1'b0}));
    if (sum < 0)         duty_nx = '0;
    else if (sum > full) duty_nx = full[DUTY_W-1:0];
    else                 duty_nx = sum[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (!down) begin
      cnt <= cnt + CNT_W'(1);
      if ({1'b0, cnt} + DUTY_W'(1) >= {1'b0, period_i}) down <= 1'b1;
    end else if (cnt <= CNT_W'(1)) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      duty_q <= '0;
    end else begin
      phase <= phase_nx;
      if (load) duty_q <= duty_nx;
    end
  end

  assign active       = down ? ({cnt, 1'b0} <= duty_q) : ({cnt, 1'b0} < duty_q);
  assign pwm_o        = (en & active) ^ invert_i;
  assign period_end_o = period_end;

  // R1: an enabled up-count that reaches the top turns downward
  p_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && ({1'b0, cnt} + DUTY_W'(1) >= {1'b0, period_i})) |=> down);

  // R7: duty register moves only at a period boundary or while idle
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(period_end_o)) |-> $stable(duty_q));

  // R6: a loaded duty never exceeds full scale
  p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && $stable(period_i)) |-> (duty_q <= {period_i, 1'b0}));

  // R9: idle output is inactive and silent
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_o == invert_i && !period_end_o));

  // R10: the strobe lasts a single cycle
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> !period_end_o);
endmodule

// File: tb/tb_composite_pwm_gen.sv
`timescale 1ns/1ps
module tb_composite_pwm_gen;
  logic clk = 0, rst_n = 0, en = 0, invert_i = 0;
  logic [7:0] period_i = 8'd25, amp_pos_i = 8'd7, amp_neg_i = 8'd2;
  logic [8:0] level_i = 9'd38;
  logic [15:0] step_i = 16'd1024;
  logic pwm_o, period_end_o;

  composite_pwm_gen dut (.clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
    .level_i(level_i), .amp_pos_i(amp_pos_i), .amp_neg_i(amp_neg_i), .step_i(step_i),
    .invert_i(invert_i), .pwm_o(pwm_o), .period_end_o(period_end_o));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_per = 0;
  int hi = 0, len = 0, exp_d = 0, phase_m = 0;
  bit run = 0;
  string tag = "R2";

  function automatic int exp_duty(int ph, int lv, int ap, int an, int per);
    int idx, s, a, q, t;
    real r;
    idx = (ph >> 10) & 63;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * idx / 64.0);
    s = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    a = (s < 0) ? an : ap;
    q = (s * a) / 127;
    t = lv + q;
    if (t < 0) t = 0;
    if (t > 2 * per) t = 2 * per;
    return t;
  endfunction

  task automatic check(bit ok, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      hi  += int'(pwm_o ^ invert_i);
      len++;
      if (period_end_o) begin
        check(len == 2 * int'(period_i), "R1/R10 period length", len, 2 * int'(period_i));
        check(hi == exp_d, {tag, " active cycles"}, hi, exp_d);
        n_per++;
        phase_m = (phase_m + int'(step_i)) & 16'hFFFF;
        exp_d = exp_duty(phase_m, level_i, amp_pos_i, amp_neg_i, period_i);
        hi = 0;
        len = 0;
      end
    end
  end

  task automatic idle_check(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(pwm_o == invert_i, "R9 idle level", pwm_o, invert_i);
      check(period_end_o == 1'b0, "R9 idle strobe", period_end_o, 0);
    end
  endtask

  task automatic run_cfg(string t, int p, int lv, int ap, int an, int st, bit inv, int periods);
    int target;
    @(posedge clk); #1;
    tag = t; period_i = 8'(p); level_i = 9'(lv); amp_pos_i = 8'(ap);
    amp_neg_i = 8'(an); step_i = 16'(st); invert_i = inv;
    idle_check(3);
    @(posedge clk); #1;
    exp_d = exp_duty(phase_m, lv, ap, an, p);
    hi = 0; len = 0; run = 1; en = 1;
    target = n_per + periods;
    wait (n_per >= target);
    @(posedge clk); #1;
    en = 0; run = 0;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    check(pwm_o == 1'b0, "R9 reset level", pwm_o, 0);
    check(period_end_o == 1'b0, "R9 reset strobe", period_end_o, 0);
    @(posedge clk); #1 rst_n = 1;
    // R3 R4 R5: one table entry per period, full sine
    run_cfg("R4/R5", 25, 38, 7, 2, 1024, 0, 64);
    // R3: non-aligned step
    run_cfg("R3", 25, 38, 7, 2, 3000, 0, 40);
    // R6: clamp at full scale and at zero
    run_cfg("R6 high", 10, 18, 200, 0, 2048, 0, 32);
    run_cfg("R6 low", 10, 3, 0, 255, 2048, 0, 32);
    // R8: inverted output
    run_cfg("R8", 7, 7, 7, 5, 4096, 1, 16);
    idle_check(4);
    // R1 R2: smallest half-period
    run_cfg("R2", 1, 1, 1, 1, 8192, 0, 10);
    // R7: level change mid-period takes effect next period
    fork
      run_cfg("R7", 25, 38, 7, 2, 1024, 0, 3);
      begin
        repeat (6) @(posedge clk);
        #1 level_i = 9'd20;
      end
    join
    idle_check(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule